// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

The block receives characters from an asynchronous serial line. A sample-tick input sets the bit rate, and each bit lasts sixteen ticks. A character is a low start bit, eight data bits sent least significant bit first, an optional parity bit, and one or two stop bits. Each completed character goes to a receive data register. A three-bit status word records three conditions: a character is waiting, the stop bit was bad, or the parity was bad.

Software uses a one-bit-address register port. Address 0 reads the data register. Address 1 reads and clears the status word. A status flag clears only when software first reads it as 1 and then writes 0 to it. While either error flag is set, the receiver ignores the line, so nothing can arrive until software has dealt with the error. Four static inputs set the line format and turn reception on or off: receive enable, parity enable, odd/even select and stop-bit count.

Top module: `uart_rx_flags`

## Requirements
- R1: After reset, every status flag reads 0 and the data register reads 0x00.
- R2: A falling edge on the idle line starts a frame when the line is still low half a bit later. Each data bit is sampled in mid-bit, the first one received going to bit 0. A good character is written to the data register and sets the receive-full flag (status bit 0).
- R3: With parity enabled, the frame-parity flag (status bit 2) is set when the parity check fails. The check is the XOR of the eight data bits and the parity bit, and it must be 0 for even parity (odd select = 0) and 1 for odd parity (odd select = 1). With parity disabled, no parity bit is expected.
- R4: A first stop bit sampled as 0 sets the stop-error flag (status bit 1). When a character has both faults, both error flags are set.
- R5: In two-stop-bit mode only the first stop bit is checked. A low second stop bit raises no error, and the next frame is still received.
- R6: A character with a stop or parity error is still written to the data register, but it does not set receive-full.
- R7: While the stop-error or frame-parity flag is 1, no new frame starts. Incoming characters leave the data register and the flags unchanged.
- R8: A status flag clears only when a status write has 0 in its bit after a status read that returned that bit as 1. A write of 0 with no such earlier read has no effect, and neither does a write of 1.
- R9: A good character that completes while receive-full is 1 is discarded, and the data register keeps the earlier character.
- R10: While receive enable is 0, no frame is received and the error flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| sampleTick | input | 1 | One-cycle pulse at sixteen times the bit rate |
| rxLine | input | 1 | Serial input, idle high |
| rxEnable | input | 1 | Reception allowed when 1 |
| parityEnable | input | 1 | Parity bit expected when 1 |
| parityOdd | input | 1 | 1 selects odd parity, 0 even |
| twoStop | input | 1 | 1 selects two stop bits |
| regSel | input | 1 | 0 data register, 1 status word |
| regRd | input | 1 | Read strobe; a status read arms the flags it returns as 1 |
| regWr | input | 1 | Write strobe, status word only |
| regWdata | input | 8 | Write data; bits 2..0 address the flags |
| regRdata | output | 8 | Read data, combinational from regSel |

## Verification
The line goes through a two-flop synchronizer. The data register and the flags then change on the clock edge after the first stop bit's mid-bit tick. The bench drives two idle bit times after each stop bit, and only after that does the monitor read the registers, so every result is already in place. A read returns the selected register in the same cycle, and the bench samples it just after the falling edge. A status write takes effect at the next rising edge, and each following read starts a full cycle later. The reference model is updated when each frame ends, and that order decides whether an item is delivered, discarded, loaded as an error or ignored.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_STOP2
  } rxState_t;

  typedef struct packed {
    logic shiftBit;
    logic capParity;
    logic finish;
  } rxStrobe_t;

  localparam logic ADDR_DATA   = 1'b0;
  localparam logic ADDR_STATUS = 1'b1;
  localparam int   NFLAGS      = 3;
  localparam int   BIT_FULL    = 0;
  localparam int   BIT_FERR    = 1;
  localparam int   BIT_PERR    = 2;
endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      lineS,
  input  logic      rxEnable,
  input  logic      parityEnable,
  input  logic      twoStop,
  input  logic      stall,
  output rxStrobe_t strobe,
  output logic      busy
);
  localparam int CW = $clog2(OVERSAMPLE);
  localparam int BW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CW-1:0] LAST_TICK = CW'(OVERSAMPLE - 1);
  localparam logic [CW-1:0] MID_TICK  = CW'(OVERSAMPLE / 2 - 1);
  localparam logic [BW-1:0] LAST_BIT  = BW'(DATA_BITS - 1);

  rxState_t      state;
  logic [CW-1:0] tickCnt;
  logic [BW-1:0] bitIdx;
  logic          prevLine;
  logic          atEnd;

  assign atEnd = tick && rxEnable && (tickCnt == LAST_TICK);
  assign busy  = (state != S_IDLE);

  always_comb begin
    strobe           = '0;
    strobe.shiftBit  = atEnd && (state == S_DATA);
    strobe.capParity = atEnd && (state == S_PAR);
    strobe.finish    = atEnd && (state == S_STOP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      tickCnt  <= '0;
      bitIdx   <= '0;
      prevLine <= 1'b1;
    end else begin
      if (tick) prevLine <= lineS;
      if (!rxEnable) begin
        state   <= S_IDLE;
        tickCnt <= '0;
        bitIdx  <= '0;
      end else if (tick) begin
        unique case (state)
          S_IDLE: begin
            tickCnt <= '0;
            bitIdx  <= '0;
            if (!stall && prevLine && !lineS) state <= S_START;
          end
          S_START: begin
            if (tickCnt == MID_TICK) begin
              tickCnt <= '0;
              state   <= lineS ? S_IDLE : S_DATA;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
          S_DATA: begin
            if (tickCnt == LAST_TICK) begin
              tickCnt <= '0;
              if (bitIdx == LAST_BIT) begin
                bitIdx <= '0;
                state  <= parityEnable ? S_PAR : S_STOP;
              end else begin
                bitIdx <= bitIdx + 1'b1;
              end
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
          S_PAR: begin
            if (tickCnt == LAST_TICK) begin
              tickCnt <= '0;
              state   <= S_STOP;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
          S_STOP: begin
            if (tickCnt == LAST_TICK) begin
              tickCnt <= '0;
              state   <= twoStop ? S_STOP2 : S_IDLE;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
          S_STOP2: begin
            if (tickCnt == LAST_TICK) begin
              tickCnt <= '0;
              state   <= S_IDLE;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_dp.sv
module uart_rx_dp
  import uart_rx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineS,
  input  logic              parityEnable,
  input  logic              parityOdd,
  input  rxStrobe_t         strobe,
  input  logic              regSel,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [NFLAGS-1:0] wrFlags,
  output logic [DW-1:0]     regRdata,
  output logic [DW-1:0]     dataReg,
  output logic [NFLAGS-1:0] flags,
  output logic              stall
);
  logic [DW-1:0]     shiftReg;
  logic              parityBit;
  logic              badParity;
  logic              badStop;
  logic              anyErr;
  logic              statusRead;
  logic              statusWrite;
  logic [NFLAGS-1:0] armed;
  logic [NFLAGS-1:0] setVec;
  logic [NFLAGS-1:0] clrVec;

  assign stall       = flags[BIT_FERR] | flags[BIT_PERR];
  assign statusRead  = regRd && (regSel == ADDR_STATUS);
  assign statusWrite = regWr && (regSel == ADDR_STATUS);
  assign badParity   = parityEnable && ((^shiftReg ^ parityBit) != parityOdd);
  assign badStop     = !lineS;
  assign anyErr      = badParity || badStop;

  always_comb begin
    setVec           = '0;
    setVec[BIT_FULL] = strobe.finish && !anyErr && !flags[BIT_FULL];
    setVec[BIT_FERR] = strobe.finish && badStop;
    setVec[BIT_PERR] = strobe.finish && badParity;
  end

  assign clrVec   = {NFLAGS{statusWrite}} & ~wrFlags & armed;
  assign regRdata = (regSel == ADDR_STATUS) ? DW'(flags) : dataReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      parityBit <= 1'b0;
      dataReg   <= '0;
    end else begin
      if (strobe.shiftBit)  shiftReg  <= {lineS, shiftReg[DW-1:1]};
      if (strobe.capParity) parityBit <= lineS;
      if (strobe.finish && (anyErr || !flags[BIT_FULL])) dataReg <= shiftReg;
    end
  end

  for (genvar i = 0; i < NFLAGS; i++) begin : gFlag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flags[i] <= 1'b0;
        armed[i] <= 1'b0;
      end else begin
        if (setVec[i])      flags[i] <= 1'b1;
        else if (clrVec[i]) flags[i] <= 1'b0;
        if (clrVec[i])                     armed[i] <= 1'b0;
        else if (statusRead && flags[i])   armed[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sampleTick,
  input  logic                 rxLine,
  input  logic                 rxEnable,
  input  logic                 parityEnable,
  input  logic                 parityOdd,
  input  logic                 twoStop,
  input  logic                 regSel,
  input  logic                 regRd,
  input  logic                 regWr,
  input  logic [DATA_BITS-1:0] regWdata,
  output logic [DATA_BITS-1:0] regRdata
);
  logic [1:0]          syncLine;
  logic                lineS;
  logic                stall;
  logic                busy;
  rxStrobe_t           strobe;
  logic [DATA_BITS-1:0] dataReg;
  logic [NFLAGS-1:0]   flags;
  logic                unusedWdata;

  assign unusedWdata = ^regWdata[DATA_BITS-1:NFLAGS];
  assign lineS       = syncLine[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncLine <= 2'b11;
    else       syncLine <= {syncLine[0], rxLine};
  end

  uart_rx_ctrl #(.OVERSAMPLE(OVERSAMPLE), .DATA_BITS(DATA_BITS)) uCtrl (
    .clk(clk), .rstN(rstN), .tick(sampleTick), .lineS(lineS),
    .rxEnable(rxEnable), .parityEnable(parityEnable), .twoStop(twoStop),
    .stall(stall), .strobe(strobe), .busy(busy)
  );

  uart_rx_dp #(.DW(DATA_BITS)) uDp (
    .clk(clk), .rstN(rstN), .lineS(lineS), .parityEnable(parityEnable),
    .parityOdd(parityOdd), .strobe(strobe), .regSel(regSel), .regRd(regRd),
    .regWr(regWr), .wrFlags(regWdata[NFLAGS-1:0]), .regRdata(regRdata),
    .dataReg(dataReg), .flags(flags), .stall(stall)
  );
endmodule

// File: rtl/uart_rx_flags_checker.sv
module uart_rx_flags_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          busy,
  input logic          rxEnable,
  input logic          rxFull,
  input logic          frameErr,
  input logic          parityErr,
  input logic [DW-1:0] dataReg,
  input logic          regSel,
  input logic          regWr,
  input logic [2:0]    wrFlags
);
  assert_stall_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && (frameErr || parityErr)) |=> !busy);

  assert_disabled_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> !busy);

  assert_err_no_full_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(frameErr) || $rose(parityErr)) |-> !$rose(rxFull));

  assert_full_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxFull) |-> $past(regWr && regSel && !wrFlags[0]));

  assert_ferr_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frameErr) |-> $past(regWr && regSel && !wrFlags[1]));

  assert_perr_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(parityErr) |-> $past(regWr && regSel && !wrFlags[2]));

  assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dataReg) |-> ($rose(rxFull) || $rose(frameErr) || $rose(parityErr)));
endmodule

bind uart_rx_flags uart_rx_flags_checker #(.DW(DATA_BITS)) uChk (
  .clk(clk), .rstN(rstN), .busy(busy), .rxEnable(rxEnable),
  .rxFull(flags[0]), .frameErr(flags[1]), .parityErr(flags[2]),
  .dataReg(dataReg), .regSel(regSel), .regWr(regWr),
  .wrFlags(regWdata[2:0])
);

// File: tb/tb_uart_rx_flags.sv
module tb_uart_rx_flags;
  logic       clk = 0, rstN = 0, sampleTick = 0, rxLine = 1;
  logic       rxEnable = 1, parityEnable = 0, parityOdd = 0, twoStop = 0;
  logic       regSel = 0, regRd = 0, regWr = 0;
  logic [7:0] regWdata = 0;
  logic [7:0] regRdata;

  int checks = 0, failures = 0;
  bit done = 0, monBusy = 0;

  typedef struct { logic [7:0] data; logic [2:0] stat; bit chkStat; string req; } item_t;
  item_t q[$];

  logic [7:0] mData  = 0;
  logic [2:0] mFlags = 0;
  logic [2:0] mArmed = 0;

  uart_rx_flags dut (.*);

  always #5 clk = ~clk;
  always @(negedge clk) sampleTick <= ~sampleTick;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rdReg(input logic sel, output logic [7:0] val);
    @(negedge clk);
    regSel = sel; regRd = 1;
    #1 val = regRdata;
    @(negedge clk);
    regRd = 0;
  endtask

  task automatic readStatus(input string req);
    logic [7:0] v;
    rdReg(1'b1, v);
    chk(req, v, {5'b0, mFlags});
    mArmed |= mFlags;
  endtask

  task automatic writeStatus(input logic [7:0] val);
    @(negedge clk);
    regSel = 1; regWr = 1; regWdata = val;
    @(negedge clk);
    regWr = 0;
    for (int i = 0; i < 3; i++)
      if (!val[i] && mArmed[i]) begin mFlags[i] = 0; mArmed[i] = 0; end
  endtask

  task automatic clearAll(input string req);
    readStatus(req);
    writeStatus(8'h00);
  endtask

  task automatic pushWait(input bit chkStat, input string req);
    item_t it;
    it.data = mData; it.stat = mFlags; it.chkStat = chkStat; it.req = req;
    q.push_back(it);
    @(negedge clk);
    wait (q.size() == 0 && !monBusy);
  endtask

  task automatic lineBit(input logic b);
    rxLine = b;
    repeat (32) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input bit flipPar, input bit stopA,
                           input bit stopB, input bit chkStat, input string req);
    bit fe, pe;
    lineBit(1); lineBit(1);
    lineBit(0);
    for (int i = 0; i < 8; i++) lineBit(d[i]);
    if (parityEnable) lineBit((^d) ^ parityOdd ^ flipPar);
    lineBit(stopA);
    if (twoStop) lineBit(stopB);
    lineBit(1); lineBit(1);
    if (rxEnable && !(mFlags[1] || mFlags[2])) begin
      fe = !stopA;
      pe = parityEnable && flipPar;
      if (fe || pe) begin
        mData = d; mFlags[1] |= fe; mFlags[2] |= pe;
      end else if (!mFlags[0]) begin
        mData = d; mFlags[0] = 1;
      end
    end
    pushWait(chkStat, req);
  endtask

  // Monitor: pops expected items and compares against register reads
  initial begin
    item_t it;
    logic [7:0] v;
    forever begin
      wait (q.size() > 0);
      monBusy = 1;
      it = q.pop_front();
      rdReg(1'b0, v);
      chk({it.req, " data"}, v, it.data);
      if (it.chkStat) begin
        rdReg(1'b1, v);
        chk({it.req, " status"}, v, {5'b0, it.stat});
        mArmed |= it.stat;
      end
      monBusy = 0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    repeat (4) @(negedge clk);
    pushWait(1, "R1 reset");

    sendFrame(8'hA5, 0, 1, 1, 1, "R2 good frame");
    sendFrame(8'h3C, 0, 1, 1, 1, "R9 discard while full");
    clearAll("R8 read before clear");
    pushWait(1, "R8 full cleared");
    sendFrame(8'h3C, 0, 1, 1, 1, "R2 second frame");
    clearAll("R8 clear");

    parityEnable = 1; parityOdd = 0;
    sendFrame(8'h81, 0, 1, 1, 1, "R3 even parity good");
    clearAll("R8 clear");
    parityOdd = 1;
    sendFrame(8'h07, 0, 1, 1, 1, "R3 odd parity good");
    clearAll("R8 clear");

    sendFrame(8'h55, 1, 1, 1, 0, "R6 bad parity loaded");
    writeStatus(8'h00);
    pushWait(1, "R8 write without read keeps R3 flag");
    sendFrame(8'h11, 0, 1, 1, 1, "R7 stalled frame ignored");
    writeStatus(8'hFF);
    pushWait(1, "R8 write one no effect");
    writeStatus(8'h00);
    pushWait(1, "R8 parity flag cleared");

    parityEnable = 0;
    sendFrame(8'h99, 0, 0, 1, 1, "R4 stop error");
    clearAll("R8 clear");
    parityEnable = 1; parityOdd = 0;
    sendFrame(8'h6E, 1, 0, 1, 1, "R4 both errors");
    clearAll("R8 clear");

    parityEnable = 0; twoStop = 1;
    sendFrame(8'hC3, 0, 1, 0, 1, "R5 second stop low ignored");
    clearAll("R8 clear");
    sendFrame(8'h5A, 0, 1, 1, 1, "R5 next frame after two stops");
    clearAll("R8 clear");
    sendFrame(8'h24, 0, 0, 1, 1, "R5 first stop checked");

    @(negedge clk); rxEnable = 0;
    repeat (10) @(negedge clk);
    pushWait(1, "R10 flags kept while disabled");
    clearAll("R8 clear");
    twoStop = 0;
    sendFrame(8'h77, 0, 1, 1, 1, "R10 disabled frame ignored");
    @(negedge clk); rxEnable = 1;
    sendFrame(8'h78, 0, 1, 1, 1, "R10 reenabled frame");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule